// File: doc/BRIEF.md
# Next Program Counter Branch Unit

This block works out where an 8-bit accumulator machine fetches next. The fetch stage hands it one request per instruction. A request carries:

- an operation code;
- the address of the byte after the current instruction;
- the opcode byte;
- the two operand bytes and a signed relative offset;
- the accumulator and the 16-bit data pointer;
- the condition sources: carry, a selected bit, the two compare operands and a loop counter.

The block returns five things: the next program counter, a flag that says whether control left the sequential path, a request to clear the tested bit, a code-memory address for table reads, and side values for the compare and decrement forms.

Requests and results both move over valid/ready handshakes. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its result appears on the outputs one cycle later with `out_valid` high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken. All sums wrap modulo 65536.

Top module: `nxpc_unit`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0.
- R2: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid`=1 and `out_ready`=0, every output holds its value into the next cycle.
- R3: Operation 1 (short relative) gives `npc` = `seq_pc` + sign-extended `rel_off` (-128..+127), with `taken`=1.
- R4: Operation 2 (absolute) gives `npc` = {`seq_pc`[15:11], `opcode`[7:5], `byte1`}, with `taken`=1.
- R5: Operation 3 (long) gives `npc` = {`byte1`, `byte2`}. Operation 4 (indirect) gives `npc` = `dptr` + `acc`. Both set `taken`=1.
- R6: Operations 5, 6, 7 and 8 are taken when, respectively, carry=1, carry=0, bit=1 and bit=0. A taken branch gives `npc` = `seq_pc` + sign-extended `rel_off`. A branch that is not taken gives `npc` = `seq_pc` with `taken`=0.
- R7: Operation 9 (test-and-clear) sets both `taken` and `bit_clr` when `bit_in`=1, and sets neither when `bit_in`=0. `bit_clr` is 0 for every other operation.
- R8: Operation 10 is taken when `acc`=00h. Operation 11 is taken when `acc`≠00h. Both use the relative target.
- R9: Operation 12 gives `cnt_dec` = `cnt_in`−1, so 00h wraps to FFh. It is taken (relative target) exactly when `cnt_dec`≠0. For every other operation, `cnt_dec` = `cnt_in`.
- R10: Operation 13 is taken (relative target) when `cmp_a`≠`cmp_b`. It sets `cmp_carry` = (`cmp_a` < `cmp_b`, unsigned). `cmp_carry` is 0 for every other operation.
- R11: Operation 14 gives `code_addr` = `seq_pc` + `acc`. Operation 15 gives `code_addr` = `dptr` + `acc`. Both leave `npc` = `seq_pc` with `taken`=0. `code_addr` is 0 for every other operation.
- R12: Operation 0 gives `npc` = `seq_pc` with `taken`=0. Every 16-bit sum wraps modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| op | input | 4 | Operation code (0..15, see requirements) |
| seq_pc | input | 16 | Address of the following instruction |
| opcode | input | 8 | Opcode byte; bits 7:5 are the page bits |
| byte1 | input | 8 | First operand byte |
| byte2 | input | 8 | Second operand byte |
| rel_off | input | 8 | Signed relative offset |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| carry_in | input | 1 | Carry flag |
| bit_in | input | 1 | Selected bit value |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| cnt_in | input | 8 | Loop counter before decrement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| npc | output | 16 | Next program counter |
| taken | output | 1 | Control left the sequential path |
| bit_clr | output | 1 | Request to clear the tested bit |
| code_addr | output | 16 | Code address for a table read |
| cmp_carry | output | 1 | Compare carry (first operand below second) |
| cnt_dec | output | 8 | Decremented counter |

## Verification
Back-pressure and a new request can land in the same cycle. The held result must stay frozen while the upstream side keeps offering the next request. In the mixed phase, `out_ready` and `in_valid` are both driven at random, so stalls often overlap with pending requests. A cycle-level model decides which requests are actually accepted, and the outputs and `in_ready` are compared against it on every cycle. A second overlap is the test-and-clear form: it both redirects `npc` and raises `bit_clr` in one result. That form is judged against each of its two bit values.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int PAGE_W = 3;
  localparam int ABS_W  = DW + PAGE_W;

  typedef enum logic [3:0] {
    OP_SEQ    = 4'd0,
    OP_SHORT  = 4'd1,
    OP_ABS    = 4'd2,
    OP_LONG   = 4'd3,
    OP_INDIR  = 4'd4,
    OP_JC     = 4'd5,
    OP_JNC    = 4'd6,
    OP_JB     = 4'd7,
    OP_JNB    = 4'd8,
    OP_JBC    = 4'd9,
    OP_JZ     = 4'd10,
    OP_JNZ    = 4'd11,
    OP_DJNZ   = 4'd12,
    OP_CJNE   = 4'd13,
    OP_TBL_PC = 4'd14,
    OP_TBL_DP = 4'd15
  } br_op_e;

  typedef struct packed {
    logic [AW-1:0] npc;
    logic          taken;
    logic          bit_clr;
    logic [AW-1:0] code_addr;
    logic          cmp_carry;
    logic [DW-1:0] cnt_dec;
  } br_res_t;
endpackage

// File: rtl/nxpc_targets.sv
module nxpc_targets
  import nxpc_pkg::*;
(
  input  logic [AW-1:0]     seq_pc,
  input  logic [PAGE_W-1:0] page,
  input  logic [DW-1:0]     byte1,
  input  logic [DW-1:0]     byte2,
  input  logic [DW-1:0]     rel_off,
  input  logic [DW-1:0]     acc,
  input  logic [AW-1:0]     dptr,
  output logic [AW-1:0]     rel_tgt,
  output logic [AW-1:0]     abs_tgt,
  output logic [AW-1:0]     long_tgt,
  output logic [AW-1:0]     dp_acc,
  output logic [AW-1:0]     pc_acc
);
  localparam int EXT_W = AW - DW;

  logic [AW-1:0] rel_ext;
  logic [AW-1:0] acc_ext;

  assign rel_ext  = {{EXT_W{rel_off[DW-1]}}, rel_off};
  assign acc_ext  = {{EXT_W{1'b0}}, acc};
  assign rel_tgt  = seq_pc + rel_ext;
  assign abs_tgt  = {seq_pc[AW-1:ABS_W], page, byte1};
  assign long_tgt = {byte1, byte2};
  assign dp_acc   = dptr + acc_ext;
  assign pc_acc   = seq_pc + acc_ext;
endmodule

// File: rtl/nxpc_cond.sv
module nxpc_cond
  import nxpc_pkg::*;
(
  input  br_op_e        op,
  input  logic          carry_in,
  input  logic          bit_in,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] cmp_a,
  input  logic [DW-1:0] cmp_b,
  input  logic [DW-1:0] cnt_in,
  output logic          is_cond,
  output logic          cond_ok,
  output logic          bit_clr,
  output logic          cmp_carry,
  output logic [DW-1:0] cnt_dec
);
  logic [DW-1:0] cnt_m1;
  logic          acc_zero;

  assign cnt_m1   = cnt_in - {{(DW-1){1'b0}}, 1'b1};
  assign acc_zero = (acc == '0);

  always_comb begin
    is_cond   = 1'b1;
    cond_ok   = 1'b0;
    bit_clr   = 1'b0;
    cmp_carry = 1'b0;
    cnt_dec   = cnt_in;
    unique case (op)
      OP_JC:   cond_ok = carry_in;
      OP_JNC:  cond_ok = ~carry_in;
      OP_JB:   cond_ok = bit_in;
      OP_JNB:  cond_ok = ~bit_in;
      OP_JBC: begin
        cond_ok = bit_in;
        bit_clr = bit_in;
      end
      OP_JZ:   cond_ok = acc_zero;
      OP_JNZ:  cond_ok = ~acc_zero;
      OP_DJNZ: begin
        cnt_dec = cnt_m1;
        cond_ok = (cnt_m1 != '0);
      end
      OP_CJNE: begin
        cond_ok   = (cmp_a != cmp_b);
        cmp_carry = (cmp_a < cmp_b);
      end
      default: is_cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    op,
  input  logic [AW-1:0] seq_pc,
  input  logic [DW-1:0] opcode,
  input  logic [DW-1:0] byte1,
  input  logic [DW-1:0] byte2,
  input  logic [DW-1:0] rel_off,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] dptr,
  input  logic          carry_in,
  input  logic          bit_in,
  input  logic [DW-1:0] cmp_a,
  input  logic [DW-1:0] cmp_b,
  input  logic [DW-1:0] cnt_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] npc,
  output logic          taken,
  output logic          bit_clr,
  output logic [AW-1:0] code_addr,
  output logic          cmp_carry,
  output logic [DW-1:0] cnt_dec
);
  br_op_e        op_e;
  logic [AW-1:0] rel_tgt, abs_tgt, long_tgt, dp_acc, pc_acc;
  logic          is_cond, cond_ok, clr_d, cy_d;
  logic [DW-1:0] cnt_d;
  br_res_t       res_d, res_q;
  logic          accept;

  assign op_e = br_op_e'(op);

  nxpc_targets u_tgt (
    .seq_pc   (seq_pc),
    .page     (opcode[DW-1:DW-PAGE_W]),
    .byte1    (byte1),
    .byte2    (byte2),
    .rel_off  (rel_off),
    .acc      (acc),
    .dptr     (dptr),
    .rel_tgt  (rel_tgt),
    .abs_tgt  (abs_tgt),
    .long_tgt (long_tgt),
    .dp_acc   (dp_acc),
    .pc_acc   (pc_acc)
  );

  nxpc_cond u_cond (
    .op        (op_e),
    .carry_in  (carry_in),
    .bit_in    (bit_in),
    .acc       (acc),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .cnt_in    (cnt_in),
    .is_cond   (is_cond),
    .cond_ok   (cond_ok),
    .bit_clr   (clr_d),
    .cmp_carry (cy_d),
    .cnt_dec   (cnt_d)
  );

  always_comb begin
    res_d           = '0;
    res_d.npc       = seq_pc;
    res_d.bit_clr   = clr_d;
    res_d.cmp_carry = cy_d;
    res_d.cnt_dec   = cnt_d;
    if (is_cond) begin
      res_d.taken = cond_ok;
      if (cond_ok) res_d.npc = rel_tgt;
    end else begin
      unique case (op_e)
        OP_SHORT:  begin res_d.npc = rel_tgt;  res_d.taken = 1'b1; end
        OP_ABS:    begin res_d.npc = abs_tgt;  res_d.taken = 1'b1; end
        OP_LONG:   begin res_d.npc = long_tgt; res_d.taken = 1'b1; end
        OP_INDIR:  begin res_d.npc = dp_acc;   res_d.taken = 1'b1; end
        OP_TBL_PC: res_d.code_addr = pc_acc;
        OP_TBL_DP: res_d.code_addr = dp_acc;
        default:   res_d.taken = 1'b0;
      endcase
    end
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res_q     <= res_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign npc       = res_q.npc;
  assign taken     = res_q.taken;
  assign bit_clr   = res_q.bit_clr;
  assign code_addr = res_q.code_addr;
  assign cmp_carry = res_q.cmp_carry;
  assign cnt_dec   = res_q.cnt_dec;
endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [3:0]  op,
  input logic [15:0] seq_pc,
  input logic [7:0]  byte1,
  input logic [7:0]  byte2,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] npc,
  input logic        taken,
  input logic        bit_clr,
  input logic        cmp_carry,
  input logic [7:0]  cnt_dec
);
  logic acc_q;
  assign acc_q = in_valid && in_ready;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(npc) && $stable(taken) && $stable(cnt_dec)); // R2
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R2
  AST_ABS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q && op == 4'd2 |=> npc[15:11] == $past(seq_pc[15:11]) && taken); // R4
  AST_LONG_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q && op == 4'd3 |=> npc == {$past(byte1), $past(byte2)}); // R5
  AST_CLR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && bit_clr |-> taken); // R7
  AST_DJNZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q && op == 4'd12 |=> taken == (cnt_dec != 8'd0)); // R9
  AST_CY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cmp_carry |-> taken); // R10
endmodule

bind nxpc_unit nxpc_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .seq_pc    (seq_pc),
  .byte1     (byte1),
  .byte2     (byte2),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .npc       (npc),
  .taken     (taken),
  .bit_clr   (bit_clr),
  .cmp_carry (cmp_carry),
  .cnt_dec   (cnt_dec)
);

// File: tb/test_nxpc_unit.sv
`timescale 1ns/1ps
module test_nxpc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [3:0]  op = '0;
  logic [15:0] seq_pc = '0, dptr = '0;
  logic [7:0]  opcode = '0, byte1 = '0, byte2 = '0, rel_off = '0, acc = '0;
  logic        carry_in = 1'b0, bit_in = 1'b0;
  logic [7:0]  cmp_a = '0, cmp_b = '0, cnt_in = '0;
  logic [15:0] npc, code_addr;
  logic        taken, bit_clr, cmp_carry;
  logic [7:0]  cnt_dec;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nxpc_unit i_nxpc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .seq_pc(seq_pc), .opcode(opcode), .byte1(byte1), .byte2(byte2), .rel_off(rel_off),
    .acc(acc), .dptr(dptr), .carry_in(carry_in), .bit_in(bit_in), .cmp_a(cmp_a),
    .cmp_b(cmp_b), .cnt_in(cnt_in), .out_valid(out_valid), .out_ready(out_ready),
    .npc(npc), .taken(taken), .bit_clr(bit_clr), .code_addr(code_addr),
    .cmp_carry(cmp_carry), .cnt_dec(cnt_dec)
  );

  // Behavioural reference: {npc, taken, bit_clr, code_addr, cmp_carry, cnt_dec}
  function automatic logic [42:0] ref_res(int o, int seq, int ob, int b1, int b2, int rl,
                                          int a, int dp, bit c, bit bt, int ca, int cb, int cn);
    int r, tgt, nx, code, cnt;
    bit tk, clr, cy;
    r = (rl > 127) ? rl - 256 : rl;
    tgt = (seq + r + 65536) % 65536;
    nx = seq; tk = 0; clr = 0; cy = 0; code = 0; cnt = cn;
    case (o)
      1:  tk = 1;
      2:  begin nx = (seq / 2048) * 2048 + ((ob / 32) % 8) * 256 + b1; tk = 1; end
      3:  begin nx = b1 * 256 + b2; tk = 1; end
      4:  begin nx = (dp + a) % 65536; tk = 1; end
      5:  tk = c;
      6:  tk = !c;
      7:  tk = bt;
      8:  tk = !bt;
      9:  begin tk = bt; clr = bt; end
      10: tk = (a == 0);
      11: tk = (a != 0);
      12: begin cnt = (cn + 255) % 256; tk = (cnt != 0); end
      13: begin tk = (ca != cb); cy = (ca < cb); end
      14: code = (seq + a) % 65536;
      15: code = (dp + a) % 65536;
      default: ;
    endcase
    if (tk && (o == 1 || (o >= 5 && o <= 13))) nx = tgt;
    return {nx[15:0], tk, clr, code[15:0], cy, cnt[7:0]};
  endfunction

  function automatic string tag_of(int o);
    case (o)
      0: return "R12"; 1: return "R3"; 2: return "R4";
      3, 4: return "R5"; 5, 6, 7, 8: return "R6"; 9: return "R7";
      10, 11: return "R8"; 12: return "R9"; 13: return "R10";
      default: return "R11";
    endcase
  endfunction

  logic        exp_valid = 1'b0;
  logic [42:0] exp_res = '0;
  int          exp_op = 0;
  bit          stalled = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      stalled   <= 0;
    end else begin
      stalled <= exp_valid && !out_ready;
      if (in_valid && (!exp_valid || out_ready)) begin
        exp_valid <= 1'b1;
        exp_op    <= int'(op);
        exp_res   <= ref_res(int'(op), int'(seq_pc), int'(opcode), int'(byte1), int'(byte2),
                             int'(rel_off), int'(acc), int'(dptr), carry_in, bit_in,
                             int'(cmp_a), int'(cmp_b), int'(cnt_in));
      end else if (out_ready) begin
        exp_valid <= 1'b0;
      end
    end
  end

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, want, $time);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      chk("R2", "in_ready", 16'(in_ready), 16'(!exp_valid || out_ready));
      chk(exp_valid ? "R2" : "R1", "out_valid", 16'(out_valid), 16'(exp_valid));
      if (exp_valid) begin
        string t;
        t = stalled ? "R2" : tag_of(exp_op);
        chk(t, "npc", npc, exp_res[42:27]);
        chk(t, "taken", 16'(taken), 16'(exp_res[26]));
        chk(stalled ? "R2" : "R7", "bit_clr", 16'(bit_clr), 16'(exp_res[25]));
        chk(stalled ? "R2" : "R11", "code_addr", code_addr, exp_res[24:9]);
        chk(stalled ? "R2" : "R10", "cmp_carry", 16'(cmp_carry), 16'(exp_res[8]));
        chk(stalled ? "R2" : "R9", "cnt_dec", 16'(cnt_dec), 16'(exp_res[7:0]));
      end
    end
  end

  task automatic put(int o, int seq, int ob, int b1, int b2, int rl, int a, int dp,
                     bit c, bit bt, int ca, int cb, int cn);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    op = 4'(o); seq_pc = 16'(seq); opcode = 8'(ob); byte1 = 8'(b1); byte2 = 8'(b2);
    rel_off = 8'(rl); acc = 8'(a); dptr = 16'(dp); carry_in = c; bit_in = bt;
    cmp_a = 8'(ca); cmp_b = 8'(cb); cn = cn; cnt_in = 8'(cn);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 out_valid in reset: got %0b expected 0", out_valid);
    end
    rst_n = 1'b1;
    // R1: first cycle after reset, idle
    @(negedge clk);
    // Directed corners
    put(0,  16'h1234, 0, 0, 0, 8'h10, 0, 0, 0, 0, 0, 0, 5);            // R12 sequential
    put(1,  16'hFFFE, 0, 0, 0, 8'h05, 0, 0, 0, 0, 0, 0, 5);            // R3 wrap up
    put(1,  16'h0010, 0, 0, 0, 8'h80, 0, 0, 0, 0, 0, 0, 5);            // R3 -128 wrap down
    put(2,  16'hF7FF, 8'hE1, 8'h3C, 0, 0, 0, 0, 0, 0, 0, 0, 5);        // R4 page 7
    put(2,  16'hA000, 8'h41, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 5);        // R4 page 2
    put(3,  16'h0000, 0, 8'hBE, 8'hEF, 0, 0, 0, 0, 0, 0, 0, 5);        // R5 long
    put(4,  16'h0000, 0, 0, 0, 0, 8'hFF, 16'hFF80, 0, 0, 0, 0, 5);     // R5 indirect wrap
    put(5,  16'h0100, 0, 0, 0, 8'h7F, 0, 0, 1, 0, 0, 0, 5);            // R6 carry set
    put(5,  16'h0100, 0, 0, 0, 8'h7F, 0, 0, 0, 0, 0, 0, 5);            // R6 not taken
    put(6,  16'h0100, 0, 0, 0, 8'hF0, 0, 0, 0, 0, 0, 0, 5);            // R6
    put(7,  16'h0200, 0, 0, 0, 8'h02, 0, 0, 0, 1, 0, 0, 5);            // R6
    put(8,  16'h0200, 0, 0, 0, 8'h02, 0, 0, 0, 1, 0, 0, 5);            // R6
    put(9,  16'h0300, 0, 0, 0, 8'h04, 0, 0, 0, 1, 0, 0, 5);            // R7 set
    put(9,  16'h0300, 0, 0, 0, 8'h04, 0, 0, 0, 0, 0, 0, 5);            // R7 clear
    put(10, 16'h0400, 0, 0, 0, 8'h08, 8'h00, 0, 0, 0, 0, 0, 5);        // R8
    put(11, 16'h0400, 0, 0, 0, 8'h08, 8'h00, 0, 0, 0, 0, 0, 5);        // R8
    put(12, 16'h0500, 0, 0, 0, 8'hFC, 0, 0, 0, 0, 0, 0, 1);            // R9 to zero
    put(12, 16'h0500, 0, 0, 0, 8'hFC, 0, 0, 0, 0, 0, 0, 0);            // R9 wrap FF
    put(13, 16'h0600, 0, 0, 0, 8'h10, 0, 0, 0, 0, 8'h10, 8'h20, 5);    // R10 less
    put(13, 16'h0600, 0, 0, 0, 8'h10, 0, 0, 0, 0, 8'h20, 8'h10, 5);    // R10 greater
    put(13, 16'h0600, 0, 0, 0, 8'h10, 0, 0, 0, 0, 8'h33, 8'h33, 5);    // R10 equal
    put(14, 16'hFFF0, 0, 0, 0, 8'h10, 8'h20, 0, 0, 0, 0, 0, 5);        // R11 pc wrap
    put(15, 16'h0000, 0, 0, 0, 0, 8'h05, 16'h1234, 0, 0, 0, 0, 5);     // R11 dptr
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    // Mixed phase: random requests under random back-pressure (R2 overlap)
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      in_valid  = 1'($urandom);
      out_ready = ($urandom % 4) != 0;
      op = 4'($urandom); seq_pc = 16'($urandom); opcode = 8'($urandom);
      byte1 = 8'($urandom); byte2 = 8'($urandom); rel_off = 8'($urandom);
      acc = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom); dptr = 16'($urandom);
      carry_in = 1'($urandom); bit_in = 1'($urandom);
      cmp_a = 8'($urandom % 4); cmp_b = 8'($urandom % 4); cnt_in = 8'($urandom % 3);
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule